// File: doc/BRIEF.md
# Buffered Master-Only SPI Port on a UART Datapath

This block turns a UART-style transmit and receive datapath into a master-only SPI port. Writing a byte starts an 8-bit exchange. The block drives the serial clock and the data output, and it samples the data input. A received byte is read back through a separate read port. A receive-only exchange still needs a dummy write, because the transmitter owns the clock.

Each direction has buffering. On the transmit side, a one-byte holding buffer sits in front of the shift register. A byte written while a frame is shifting waits in that buffer. It starts as soon as the shift register frees up. On the receive side, a two-entry queue holds finished bytes while a third byte can still be shifting in.

Software sets the clock polarity, clock phase, bit order and an integer divider. The divider is the only rate control. The block reports three flags: buffer-empty, transfer-done and receive-ready. No error flags exist in this mode.

Top module: `spi_usart_master`

## Requirements
- R1: While no frame is in progress, `sck` equals `cpol`. Each frame is exactly 16 clock edges, and after them `sck` is back at `cpol`.
- R2: Consecutive `sck` edges within a frame are exactly `baud_div`+1 clock cycles apart, so the serial clock runs at clk/(2·(`baud_div`+1)).
- R3: With `cpha`=0, `miso` is sampled on the leading (first, third, ...) edges and `mosi` changes on trailing edges. With `cpha`=1, `mosi` changes on leading edges from the second one on, and `miso` is sampled on trailing edges.
- R4: `lsb_first`=0 sends and receives bit 7 first. `lsb_first`=1 sends and receives bit 0 first. The received byte is presented with the same bit weights as the sent byte.
- R5: `dre` is high exactly when `tx_en` is high and the holding buffer is empty. A write strobe while `dre` is low is not accepted and produces no frame.
- R6: A byte written while a frame is shifting is held in the buffer. It goes out as the next frame in write order, starting the cycle after the current frame ends.
- R7: `txc` rises when a frame ends and no byte is pending in the buffer or being written in that cycle. It stays high until a cycle with `tc_clr`=1 clears it.
- R8: When `rx_en` is high at the end of a frame, the received byte is queued. `rxc` is high while the queue is non-empty, and `rd_data` shows the oldest entry. `rd_en` removes that entry. At most two bytes are held. A byte that finishes while both entries are full is discarded.
- R9: While `rx_en` is low, no byte is queued, and the queue is emptied the cycle after `rx_en` falls.
- R10: Lowering `tx_en` stops new writes from being accepted. The frame in progress and a byte already in the buffer still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; needed to accept writes |
| rx_en | input | 1 | Receiver enable; low flushes the receive queue |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | Bit order: 1 = bit 0 first |
| baud_div | input | 12 | Divider; half-period is baud_div+1 cycles |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Pops the oldest received byte |
| tc_clr | input | 1 | Clears the transfer-done flag |
| miso | input | 1 | Serial data in |
| rd_data | output | 8 | Oldest received byte |
| dre | output | 1 | Holding buffer can accept a byte |
| txc | output | 1 | Transfer-done flag |
| rxc | output | 1 | Receive queue not empty |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |

## Verification
The following internal faults show up at the ports, and quickly:

- A wrong edge counter or phase decode shows up within one frame. It yields the wrong number of `sck` edges, a clock that rests at the wrong level, or bits shifted by one position in both the sent and the received byte.
- A wrong holding-buffer state shows up within two frames. It appears as a lost, repeated or reordered byte in the `mosi` stream, or as `txc` rising between back-to-back frames.
- A wrong receive-queue pointer or count shows up on the next reads. The bytes come back in the wrong order, a third byte is not dropped, or `rxc` stays high after a flush.

// File: rtl/spi_usart_pkg.sv
package spi_usart_pkg;

    localparam int FRAME_BITS = 8;
    localparam int EC_W       = $clog2(2 * FRAME_BITS);

    typedef struct packed {
        logic                  busy;
        logic                  buf_valid;
        logic [FRAME_BITS-1:0] buf_data;
        logic [FRAME_BITS-1:0] sh;
        logic [FRAME_BITS-1:0] rx_sh;
        logic [EC_W-1:0]       ec;
        logic                  lvl;
        logic                  txc;
    } spi_state_t;

endpackage

// File: rtl/spi_baud_tick.sv
module spi_baud_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == div) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == div);
endmodule

// File: rtl/spi_rx_queue.sv
module spi_rx_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             nonempty,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } q_t;

    q_t q_d, q_q;
    logic do_pop, do_push;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d     = q_q;
        do_pop  = pop && (q_q.cnt != '0);
        do_push = push && ((q_q.cnt != CNT_W'(DEPTH)) || do_pop);
        if (do_push) begin
            q_d.mem[q_q.wp] = push_data;
            q_d.wp          = nxt(q_q.wp);
        end
        if (do_pop) q_d.rp = nxt(q_q.rp);
        case ({do_push, do_pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
        if (flush) begin
            q_d.wp  = '0;
            q_d.rp  = '0;
            q_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head     = q_q.mem[q_q.rp];
    assign nonempty = (q_q.cnt != '0);
    assign count    = q_q.cnt;
endmodule

// File: rtl/spi_usart_master.sv
module spi_usart_master
    import spi_usart_pkg::*;
#(
    parameter int DIV_W    = 12,
    parameter int RX_DEPTH = 2,
    localparam int RC_W    = $clog2(RX_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_en,
    input  logic                  rx_en,
    input  logic                  cpol,
    input  logic                  cpha,
    input  logic                  lsb_first,
    input  logic [DIV_W-1:0]      baud_div,
    input  logic                  wr_en,
    input  logic [FRAME_BITS-1:0] wr_data,
    input  logic                  rd_en,
    input  logic                  tc_clr,
    input  logic                  miso,
    output logic [FRAME_BITS-1:0] rd_data,
    output logic                  dre,
    output logic                  txc,
    output logic                  rxc,
    output logic                  sck,
    output logic                  mosi
);
    localparam logic [EC_W-1:0] EC_LAST = EC_W'(2 * FRAME_BITS - 1);

    spi_state_t            st_d, st_q;
    logic                  tick, wr_ok, sample, shift, last, push;
    logic [FRAME_BITS-1:0] rx_next;
    logic                  busy_w, bufv_w;
    logic [RC_W-1:0]       rx_cnt;

    spi_baud_tick #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(st_q.busy), .div(baud_div), .tick(tick)
    );

    always_comb begin
        st_d    = st_q;
        push    = 1'b0;
        wr_ok   = wr_en && tx_en && !st_q.buf_valid;
        // even ec = leading edge; sample edges are those whose parity matches cpha
        sample  = (st_q.ec[0] == cpha);
        last    = (st_q.ec == EC_LAST);
        shift   = !sample && (st_q.ec != '0) && !last;
        rx_next = st_q.rx_sh;
        if (sample)
            rx_next = lsb_first ? {miso, st_q.rx_sh[FRAME_BITS-1:1]}
                                : {st_q.rx_sh[FRAME_BITS-2:0], miso};

        if (tc_clr) st_d.txc = 1'b0;

        if (wr_ok) begin
            st_d.buf_valid = 1'b1;
            st_d.buf_data  = wr_data;
        end

        if (!st_q.busy) begin
            if (st_q.buf_valid) begin
                st_d.busy      = 1'b1;
                st_d.sh        = st_q.buf_data;
                st_d.buf_valid = 1'b0;
                st_d.ec        = '0;
                st_d.lvl       = 1'b0;
                st_d.rx_sh     = '0;
            end
        end else if (tick) begin
            st_d.lvl   = !st_q.lvl;
            st_d.ec    = st_q.ec + 1'b1;
            st_d.rx_sh = rx_next;
            if (shift)
                st_d.sh = lsb_first ? {1'b0, st_q.sh[FRAME_BITS-1:1]}
                                    : {st_q.sh[FRAME_BITS-2:0], 1'b0};
            if (last) begin
                st_d.busy = 1'b0;
                push      = rx_en;
                if (!st_q.buf_valid && !wr_ok) st_d.txc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    spi_rx_queue #(.W(FRAME_BITS), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(push),
        .push_data(rx_next), .pop(rd_en), .head(rd_data),
        .nonempty(rxc), .count(rx_cnt)
    );

    assign busy_w = st_q.busy;
    assign bufv_w = st_q.buf_valid;
    assign sck    = cpol ^ st_q.lvl;
    assign mosi   = lsb_first ? st_q.sh[0] : st_q.sh[FRAME_BITS-1];
    assign dre    = tx_en && !st_q.buf_valid;
    assign txc    = st_q.txc;
endmodule

// File: rtl/spi_usart_master_chk.sv
module spi_usart_master_chk #(
    parameter int RX_DEPTH = 2,
    parameter int RC_W     = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tx_en,
    input logic            rx_en,
    input logic            wr_en,
    input logic            tc_clr,
    input logic            cpol,
    input logic            sck,
    input logic            txc,
    input logic            rxc,
    input logic            busy,
    input logic            buf_valid,
    input logic [RC_W-1:0] rx_cnt
);
    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol)); // R1

    AST_BUF_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && !busy) |=> busy); // R6

    AST_TXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (txc && !tc_clr) |=> txc); // R7

    AST_TXC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clr && !busy) |=> !txc); // R7

    AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= RC_W'(RX_DEPTH)); // R8

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rxc); // R9

    AST_TX_OFF_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && wr_en && !buf_valid && !busy) |=> (!buf_valid && !busy)); // R10
endmodule

bind spi_usart_master spi_usart_master_chk #(.RX_DEPTH(RX_DEPTH), .RC_W(RC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .wr_en(wr_en),
    .tc_clr(tc_clr), .cpol(cpol), .sck(sck), .txc(txc), .rxc(rxc),
    .busy(busy_w), .buf_valid(bufv_w), .rx_cnt(rx_cnt)
);

// File: tb/sim_spi_usart_master.sv
module sim_spi_usart_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, rx_en = 1'b0, cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
    logic [11:0] baud_div = 12'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0, tc_clr = 1'b0, miso = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        dre, txc, rxc, sck, mosi;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_usart_master u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .cpol(cpol),
        .cpha(cpha), .lsb_first(lsb_first), .baud_div(baud_div), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .tc_clr(tc_clr), .miso(miso),
        .rd_data(rd_data), .dre(dre), .txc(txc), .rxc(rxc), .sck(sck), .mosi(mosi)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
        end
    endtask

    // bit sent at position i of a frame (i=0 first)
    function automatic int bitpos(input int i, input logic lsb);
        return lsb ? i : 7 - i;
    endfunction

    // slave model: observes sck, drives miso, collects mosi
    logic [7:0] slave_q [64];
    logic [7:0] mosi_log [64];
    int   frames = 0, ecount = 0, since = 0;
    bit   per_bad = 0;
    logic prev_sck = 1'b0;
    logic [7:0] mcap = 8'h00;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sck = cpol; ecount = 0; since = 0;
        end else begin
            since++;
            if (sck !== prev_sck && (ecount > 0 || sck !== cpol)) begin
                int e;
                bit lead;
                e    = ecount + 1;
                lead = (prev_sck === cpol);
                if (ecount > 0 && since != int'(baud_div) + 1) per_bad = 1;
                since = 0;
                if (lead) begin
                    if (!cpha) mcap[bitpos((e - 1) / 2, lsb_first)] = mosi;
                    else       miso = slave_q[frames % 64][bitpos((e - 1) / 2, lsb_first)];
                end else begin
                    if (!cpha) begin
                        if (e < 16) miso = slave_q[frames % 64][bitpos(e / 2, lsb_first)];
                    end else mcap[bitpos(e / 2 - 1, lsb_first)] = mosi;
                end
                ecount = e;
                if (e == 16) begin
                    mosi_log[frames % 64] = mcap;
                    frames++;
                    ecount = 0;
                end
            end
            if (ecount == 0) miso = slave_q[frames % 64][bitpos(0, lsb_first)];
            prev_sck = sck;
        end
    end

    task automatic wait_frames(input int target);
        for (int g = 0; g < 100000 && frames < target; g++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_dre();
        for (int g = 0; g < 100000 && !dre; g++) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_byte();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic one_frame(input logic [7:0] tx, input logic [7:0] slv, input string tag);
        int f0;
        f0 = frames;
        slave_q[f0 % 64] = slv;
        per_bad = 0;
        wait_dre();
        write_byte(tx);
        wait_frames(f0 + 1);
        check(mosi_log[f0 % 64] == tx, {tag, " R3 R4 mosi byte"}, mosi_log[f0 % 64], tx);
        check(rxc && rd_data == slv, {tag, " R3 R4 R8 received byte"}, rd_data, slv);
        pop_byte();
        check(!per_bad, {tag, " R2 half-period"}, per_bad, 0);
        check(sck == cpol, {tag, " R1 sck idle"}, sck, cpol);
    endtask

    initial begin
        int f0;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 64; i++) slave_q[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check(sck == 1'b0 && !txc && !rxc, "R1 reset outputs", {sck, txc, rxc}, 0);
        check(dre == 1'b0, "R5 dre low while tx disabled", dre, 0);
        write_byte(8'hA5);
        repeat (40) @(negedge clk);
        check(frames == 0 && sck == cpol, "R10 write ignored while tx disabled", frames, 0);

        tx_en = 1'b1; rx_en = 1'b1;
        @(negedge clk);
        check(dre == 1'b1, "R5 dre high with empty buffer", dre, 1);

        // directed modes
        one_frame(8'h81, 8'h3C, "mode00 msb");
        lsb_first = 1'b1;
        one_frame(8'h81, 8'h3C, "mode00 lsb");
        cpha = 1'b1; cpol = 1'b1; lsb_first = 1'b0; baud_div = 12'd37;
        one_frame(8'hC3, 8'h5A, "mode11 div37");
        baud_div = 12'd0;
        one_frame(8'h01, 8'h80, "mode11 div0");

        // random
        for (int i = 0; i < 20; i++) begin
            cpol = 1'($urandom); cpha = 1'($urandom); lsb_first = 1'($urandom);
            baud_div = 12'($urandom % 4);
            @(negedge clk);
            one_frame(8'($urandom), 8'($urandom), "random");
        end

        // R7 clear then back-to-back, R6 ordering
        cpol = 1'b0; cpha = 1'b0; lsb_first = 1'b0; baud_div = 12'd1;
        tc_clr = 1'b1; @(negedge clk); tc_clr = 1'b0;
        check(!txc, "R7 txc cleared", txc, 0);
        f0 = frames;
        slave_q[f0 % 64] = 8'h11; slave_q[(f0 + 1) % 64] = 8'h22; slave_q[(f0 + 2) % 64] = 8'h33;
        write_byte(8'hD1);
        wait_dre();
        write_byte(8'hD2);
        check(!dre, "R5 dre low while buffer holds byte", dre, 0);
        write_byte(8'hEE);   // buffer full: ignored
        wait_frames(f0 + 1);
        check(!txc, "R7 no txc between back-to-back frames", txc, 0);
        wait_frames(f0 + 2);
        repeat (60) @(negedge clk);
        check(frames == f0 + 2, "R5 write while full not accepted", frames, f0 + 2);
        check(mosi_log[f0 % 64] == 8'hD1 && mosi_log[(f0 + 1) % 64] == 8'hD2,
              "R6 write order kept", mosi_log[(f0 + 1) % 64], 8'hD2);
        check(txc, "R7 txc set after last frame", txc, 1);
        repeat (5) @(negedge clk);
        check(txc, "R7 txc holds", txc, 1);

        // third byte while two held: dropped
        write_byte(8'hD3);
        wait_frames(f0 + 3);
        check(rxc && rd_data == 8'h11, "R8 oldest entry first", rd_data, 8'h11);
        pop_byte();
        check(rxc && rd_data == 8'h22, "R8 second entry", rd_data, 8'h22);
        pop_byte();
        check(!rxc, "R8 third byte dropped when full", rxc, 0);

        // R9 receiver disabled
        rx_en = 1'b0;
        one_frame_norx();
        check(!rxc, "R9 nothing queued with rx disabled", rxc, 0);
        rx_en = 1'b1;
        f0 = frames;
        slave_q[f0 % 64] = 8'h44;
        write_byte(8'h55);
        wait_frames(f0 + 1);
        check(rxc, "R8 byte queued", rxc, 1);
        rx_en = 1'b0; @(negedge clk); rx_en = 1'b1; @(negedge clk);
        check(!rxc, "R9 flush on disable", rxc, 0);

        // R10 tx disable lets pending bytes finish
        f0 = frames;
        write_byte(8'h6A);
        wait_dre();
        write_byte(8'h6B);
        tx_en = 1'b0;
        write_byte(8'h6C);
        wait_frames(f0 + 2);
        repeat (60) @(negedge clk);
        check(frames == f0 + 2, "R10 frame count after disable", frames, f0 + 2);
        check(mosi_log[(f0 + 1) % 64] == 8'h6B, "R10 buffered byte completes",
              mosi_log[(f0 + 1) % 64], 8'h6B);
        check(!dre && sck == cpol, "R10 idle and no dre", dre, 0);

        done = 1;
        summary();
        $finish;
    end

    task automatic one_frame_norx();
        int f0;
        f0 = frames;
        write_byte(8'h99);
        wait_frames(f0 + 1);
        check(mosi_log[f0 % 64] == 8'h99, "R9 transmit still runs", mosi_log[f0 % 64], 8'h99);
    endtask
endmodule